// File: doc/BRIEF.md
# Delayed Branch Program Counter Sequencer

This block owns the program counter of a small processor with a 16-bit instruction address space. It is advanced once for each issued instruction. It takes transfer requests from the decoder: jump, subroutine call, return and conditional branch. A transfer target comes from one of three places: a register value, an absolute word stored after the instruction, or a signed offset added to the sequential PC. Every transfer request is followed by exactly one delay-slot instruction. A taken transfer only changes the fetch address after that slot has been issued.

A conditional branch is taken when at least one of the four ALU status flags is still set after it is masked with the branch's four condition bits. The PC used for relative targets already points at the delay-slot instruction. A call presents a return address for the stack; that address is the one after the delay slot. A return takes its target from the popped stack value. A halt request freezes sequencing until a wake-up or interrupt input arrives. A transfer or a two-word instruction placed in a delay slot is reported as illegal.

Top module: `pc_seq`

Encodings: `req_kind` 0 none, 1 jump, 2 call, 3 return, 4 branch, 5 halt. `tgt_src` 0 register, 1 absolute word, 2 relative.

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_pc` is 0 and both `halted` and `in_slot` are 0.
- R2: A step with no request moves `fetch_pc` on by 1, or by 2 when `multi_word` is high. With `step` low and no halt, `fetch_pc` holds.
- R3: A step with any transfer request (kinds 1 to 4) moves `fetch_pc` to the sequential address and raises `in_slot`. The next step issues the slot and loads the transfer outcome, which clears `in_slot`.
- R4: A branch (kind 4) is taken exactly when `status & cond_mask` is nonzero. When it is not taken, the PC after the slot is the slot address plus 1. `taken` reports the decision during the request step.
- R5: A relative target is the sequential address plus the sign-extended offset, using the low 8 bits of `rel_off` for a branch and all 12 bits for a jump or call. The sum wraps modulo 2^16.
- R6: Source 0 uses `reg_tgt`. Source 1 uses `abs_tgt` and makes the instruction two words long, so the slot sits at PC+2.
- R7: During a call's request step, `push_en` is high and `push_addr` equals the slot address plus 1. At all other times `push_en` is low.
- R8: A return (kind 3) jumps to `ret_addr` after its slot, whatever `tgt_src` is.
- R9: In a delay slot, a transfer request or `multi_word` raises `illegal` and is ignored. The PC still moves to the pending outcome.
- R10: A halt request (kind 5) sets `halted` and moves the PC on by one. While halted, steps are ignored. `wake` or `irq` clears `halted` without moving the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction issued this cycle |
| req_kind | input | 3 | Request kind of the issued instruction |
| tgt_src | input | 2 | Target source select |
| multi_word | input | 1 | Issued instruction spans two words |
| reg_tgt | input | 16 | Target from a register |
| abs_tgt | input | 16 | Target word following the instruction |
| rel_off | input | 12 | Signed relative offset |
| cond_mask | input | 4 | Branch condition mask |
| status | input | 4 | ALU status flags |
| ret_addr | input | 16 | Address popped from the stack |
| wake | input | 1 | Wake-up from halt |
| irq | input | 1 | Interrupt, also ends a halt |
| fetch_pc | output | 16 | Address of the instruction to issue |
| taken | output | 1 | Transfer decided taken in this step |
| push_en | output | 1 | Return address valid for pushing |
| push_addr | output | 16 | Return address to push |
| illegal | output | 1 | Forbidden instruction in a delay slot |
| halted | output | 1 | Sequencing is stopped |
| in_slot | output | 1 | Next issued instruction is a delay slot |

## Verification
Some rules are checked by assertions on every cycle. These cover the slot opening after a transfer and closing on the next step, `illegal` appearing only inside a slot, the frozen PC while halted, `push_en` being tied to a call, and the plain +1 advance and idle hold. Target values can only be shown by the bench scenarios. That includes the full sweep of flags against masks, relative offsets at both sign extremes with wrap-around, absolute two-word spacing, return addresses, and the PC after an illegal slot.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW   = 16,
  parameter int FW   = 4,
  parameter int BOFF = 8,
  parameter int JOFF = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    req_kind,
  input  logic [1:0]    tgt_src,
  input  logic          multi_word,
  input  logic [AW-1:0] reg_tgt,
  input  logic [AW-1:0] abs_tgt,
  input  logic [JOFF-1:0] rel_off,
  input  logic [FW-1:0] cond_mask,
  input  logic [FW-1:0] status,
  input  logic [AW-1:0] ret_addr,
  input  logic          wake,
  input  logic          irq,
  output logic [AW-1:0] fetch_pc,
  output logic          taken,
  output logic          push_en,
  output logic [AW-1:0] push_addr,
  output logic          illegal,
  output logic          halted,
  output logic          in_slot
);
  localparam logic [2:0] K_JMP = 3'd1, K_CALL = 3'd2, K_RET = 3'd3,
                         K_BR = 3'd4, K_HALT = 3'd5;
  localparam logic [1:0] S_REG = 2'd0, S_ABS = 2'd1;

  logic [AW-1:0] pc_q, tgt_q, seq_pc, rel_tgt, pick_tgt;
  logic          slot_q, halt_q;

  wire live     = step & ~halt_q;
  wire is_xfer  = (req_kind >= K_JMP) & (req_kind <= K_BR);
  wire abs_word = is_xfer & (req_kind != K_RET) & (tgt_src == S_ABS);
  wire two_word = multi_word | abs_word;
  wire cond_ok  = |(status & cond_mask);
  wire go       = is_xfer & ((req_kind != K_BR) | cond_ok);

  wire [AW-1:0] b_sx = {{(AW-BOFF){rel_off[BOFF-1]}}, rel_off[BOFF-1:0]};
  wire [AW-1:0] j_sx = {{(AW-JOFF){rel_off[JOFF-1]}}, rel_off};

  assign seq_pc  = pc_q + (two_word ? AW'(2) : AW'(1));
  assign rel_tgt = seq_pc + ((req_kind == K_BR) ? b_sx : j_sx);

  always_comb begin
    if (req_kind == K_RET)      pick_tgt = ret_addr;
    else if (tgt_src == S_REG)  pick_tgt = reg_tgt;
    else if (tgt_src == S_ABS)  pick_tgt = abs_tgt;
    else                        pick_tgt = rel_tgt;
  end

  assign fetch_pc  = pc_q;
  assign halted    = halt_q;
  assign in_slot   = slot_q;
  assign taken     = live & ~slot_q & go;
  assign push_en   = live & ~slot_q & (req_kind == K_CALL);
  assign push_addr = seq_pc + AW'(1);
  assign illegal   = live & slot_q & (is_xfer | two_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      tgt_q  <= '0;
      slot_q <= 1'b0;
      halt_q <= 1'b0;
    end else if (halt_q) begin
      if (wake | irq) halt_q <= 1'b0;
    end else if (step) begin
      if (slot_q) begin
        pc_q   <= tgt_q;
        slot_q <= 1'b0;
        halt_q <= (req_kind == K_HALT);
      end else begin
        pc_q   <= seq_pc;
        slot_q <= is_xfer;
        tgt_q  <= go ? pick_tgt : seq_pc + AW'(1);
        halt_q <= (req_kind == K_HALT);
      end
    end
  end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [2:0]  req_kind,
  input logic        multi_word,
  input logic        wake,
  input logic        irq,
  input logic [15:0] fetch_pc,
  input logic        push_en,
  input logic        illegal,
  input logic        halted,
  input logic        in_slot
);
  wire xfer = (req_kind >= 3'd1) && (req_kind <= 3'd4);

  AST_SLOT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    step && !halted && !in_slot && xfer |=> in_slot); // R3
  AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    step && !halted && in_slot |=> !in_slot); // R3
  AST_ILLEGAL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> in_slot); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !wake && !irq |=> halted && $stable(fetch_pc)); // R10
  AST_PUSH_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> req_kind == 3'd2 && !in_slot && step); // R7
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !halted && !in_slot && req_kind == 3'd0 && !multi_word
    |=> fetch_pc == $past(fetch_pc) + 16'd1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !halted |=> $stable(fetch_pc)); // R2
endmodule

bind pc_seq pc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .step(step), .req_kind(req_kind),
  .multi_word(multi_word), .wake(wake), .irq(irq), .fetch_pc(fetch_pc),
  .push_en(push_en), .illegal(illegal), .halted(halted), .in_slot(in_slot)
);

// File: tb/pc_seq_tb.sv
module pc_seq_tb_top;
  logic clk = 0, rst_n = 0, step = 0, multi_word = 0, wake = 0, irq = 0;
  logic [2:0] req_kind = 0;
  logic [1:0] tgt_src = 0;
  logic [15:0] reg_tgt = 0, abs_tgt = 0, ret_addr = 0;
  logic [11:0] rel_off = 0;
  logic [3:0] cond_mask = 0, status = 0;
  logic [15:0] fetch_pc, push_addr;
  logic taken, push_en, illegal, halted, in_slot;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pc_seq dut_i (.*);

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic drive(bit s, logic [2:0] k, logic [1:0] src, bit mw);
    @(negedge clk);
    step = s; req_kind = k; tgt_src = src; multi_word = mw;
    #1;
  endtask

  task automatic clk_in();
    @(posedge clk); #1;
    step = 0; req_kind = 0; multi_word = 0; wake = 0; irq = 0;
  endtask

  // issue a transfer then its slot; check slot address and final pc
  task automatic xfer(string r, logic [2:0] k, logic [1:0] src,
                      bit exp_tk, logic [15:0] exp_tgt);
    logic [15:0] p0, sl;
    p0 = fetch_pc;
    sl = p0 + ((src == 2'd1 && k != 3'd3) ? 16'd2 : 16'd1);
    drive(1, k, src, 0);
    chk({r, " taken"}, 16'(taken), 16'(exp_tk));
    clk_in();
    chk({r, " slot pc"}, fetch_pc, sl);
    chk({r, " in_slot"}, 16'(in_slot), 16'd1);
    drive(1, 0, 0, 0);
    clk_in();
    chk({r, " target"}, fetch_pc, exp_tk ? exp_tgt : sl + 16'd1);
  endtask

  initial begin
    logic [15:0] p, e;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc in reset", fetch_pc, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 pc", fetch_pc, 0);
    chk("R1 halted", 16'(halted), 0);
    chk("R1 in_slot", 16'(in_slot), 0);

    drive(0, 0, 0, 0); clk_in();
    chk("R2 idle hold", fetch_pc, 0);
    for (int i = 0; i < 5; i++) begin
      drive(1, 0, 0, 0); clk_in();
      chk("R2 seq", fetch_pc, 16'(i + 1));
    end
    drive(1, 0, 0, 1); clk_in();
    chk("R2 multi_word", fetch_pc, 16'd7);

    // R4 sweep: flags x mask, relative offset -16 (8-bit field)
    rel_off = 12'h7F0;
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 16; m++) begin
        status = 4'(f); cond_mask = 4'(m);
        p = fetch_pc + 16'd1;
        xfer("R4 branch", 3'd4, 2'd2, (f & m) != 0, p - 16'd16);
      end

    // R5 relative jumps, 12-bit sign extension and wrap
    foreach (rel_off_vals[i]) begin
      rel_off = rel_off_vals[i];
      p = fetch_pc + 16'd1;
      xfer("R5 jump rel", 3'd1, 2'd2, 1, p + {{4{rel_off[11]}}, rel_off});
    end
    rel_off = 12'h080; p = fetch_pc + 16'd1;
    xfer("R5 branch rel 8-bit", 3'd4, 2'd2, 1, p - 16'd128);

    // R6 register and absolute sources
    reg_tgt = 16'h1234; xfer("R6 reg", 3'd1, 2'd0, 1, 16'h1234);
    abs_tgt = 16'hBEEF; xfer("R6 abs", 3'd1, 2'd1, 1, 16'hBEEF);

    // R7 call
    reg_tgt = 16'h0400; p = fetch_pc;
    drive(1, 3'd2, 2'd0, 0);
    chk("R7 push_en", 16'(push_en), 1);
    chk("R7 push_addr", push_addr, p + 16'd2);
    clk_in();
    chk("R7 push_en low", 16'(push_en), 0);
    drive(1, 0, 0, 0); clk_in();
    chk("R7 call target", fetch_pc, 16'h0400);

    // R8 return ignores source
    ret_addr = 16'h0777; abs_tgt = 16'h1111;
    xfer("R8 ret", 3'd3, 2'd1, 1, 16'h0777);

    // R9 illegal in slot
    reg_tgt = 16'h2000; drive(1, 3'd1, 2'd0, 0); clk_in();
    reg_tgt = 16'h3000; drive(1, 3'd1, 2'd0, 0);
    chk("R9 illegal xfer", 16'(illegal), 1);
    clk_in();
    chk("R9 pc", fetch_pc, 16'h2000);
    chk("R9 no slot", 16'(in_slot), 0);
    reg_tgt = 16'h2100; drive(1, 3'd1, 2'd0, 0); clk_in();
    drive(1, 0, 0, 1);
    chk("R9 illegal multi", 16'(illegal), 1);
    clk_in();
    chk("R9 pc multi", fetch_pc, 16'h2100);
    drive(1, 0, 0, 0);
    chk("R9 illegal quiet", 16'(illegal), 0);
    clk_in();

    // R10 halt
    p = fetch_pc;
    drive(1, 3'd5, 0, 0); clk_in();
    chk("R10 halted", 16'(halted), 1);
    chk("R10 pc", fetch_pc, p + 16'd1);
    for (int i = 0; i < 3; i++) begin drive(1, 0, 0, 0); clk_in(); end
    chk("R10 frozen", fetch_pc, p + 16'd1);
    @(negedge clk); wake = 1; clk_in();
    chk("R10 wake", 16'(halted), 0);
    chk("R10 wake pc", fetch_pc, p + 16'd1);
    drive(1, 3'd5, 0, 0); clk_in();
    @(negedge clk); irq = 1; clk_in();
    chk("R10 irq", 16'(halted), 0);
    e = p + 16'd2;
    chk("R10 irq pc", fetch_pc, e);
    done = 1;
  end

  logic [11:0] rel_off_vals [6] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'h001, 12'h9AB};

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); bad++; total++;
        $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule